// File: doc/BRIEF.md
# Asynchronous static RAM strobe sequencer

This block sits between a synchronous host and one 128K x 8 asynchronous static RAM. The host raises a request with a direction flag, a 17-bit word address and, for a write, one data byte. The block converts the request into a timed sequence of chip-select, write-enable and output-enable strobes on the memory pins. It answers with a one-cycle acknowledge. On a read it also presents the byte it captured.

Every phase lasts a whole number of clock cycles. The count for each phase is the ceiling of the memory's minimum time divided by `CLK_PERIOD_NS`, and is never less than one. The minimum times come from a table selected by `SPEED_GRADE`, which takes the values 12, 15 or 20. Any other value selects the slowest row. The memory data bus is split into an output byte, an input byte and a drive enable, so the pad ring can build the bidirectional pin.

The sequencer has six named states:
- IDLE: everything is deselected, and a request is accepted here. It moves to RD_ACCESS or WR_SETUP.
- RD_ACCESS: the access wait runs. It moves to RD_TURN once the wait count finishes.
- RD_TURN: a single-cycle gap. It returns to IDLE.
- WR_SETUP: moves to WR_PULSE.
- WR_PULSE: moves to WR_RECOV.
- WR_RECOV: returns to IDLE.

Each write state moves on when its own phase count ends.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the outputs are in their idle values: `mem_cs1_n`=1, `mem_cs2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `ack`=0 and `busy`=0.
- R2: The memory is selected (`mem_cs1_n`=0 together with `mem_cs2`=1) only during an access. Otherwise it is deselected (`mem_cs1_n`=1, `mem_cs2`=0). While selected, `mem_addr` equals the address captured at acceptance.
- R3: A read holds `mem_we_n`=1 and `mem_oe_n`=0 for RD = max(1, ceil(tAA/`CLK_PERIOD_NS`)) cycles. tAA is 12, 15 or 20 ns for grades 12, 15 and 20. The block never drives the bus while `mem_oe_n`=0.
- R4: The read byte is sampled from `mem_dq_in` at the clock edge that ends the last RD cycle. `ack` and `rd_data` become valid together RD+1 rising edges after the edge where the request is first seen. `rd_data` keeps that byte until the next read completes.
- R5: A write spends one setup cycle selected with `mem_we_n`=1. It then holds `mem_we_n`=0 for WP cycles, where WP = max(ceil(tWP/T), ceil(tDW/T)+1, ceil(tAW/T)-1, 1) and T is `CLK_PERIOD_NS`. The minimum times for grades 12, 15 and 20 are tWP 8/12/15, tDW 7/8/9 and tAW 10/12/15 ns.
- R6: `mem_oe_n` stays 1 for the whole write sequence. `mem_dq_oe` rises only while `mem_we_n` is already 0, from the second pulse cycle onward. It stays 1 through the one recovery cycle after `mem_we_n` returns to 1, so it is high for WP cycles in total.
- R7: A write acknowledges once the recovery cycle ends, which is WP+3 rising edges after the request is first seen. The stored byte is `req_wdata` as captured at acceptance.
- R8: After each read, one cycle follows with the memory deselected and no driver active before any further access. This is the cycle in which `ack` is high.
- R9: A request is accepted only in IDLE, and not in a cycle where `ack` is high. A request held high across an acknowledge therefore starts one cycle later. `req_wr`, `req_addr` and `req_wdata` are ignored after acceptance. `busy` is 1 from the acceptance edge until the edge where `ack` rises.
- R10: Phase counts follow the parameters. With `CLK_PERIOD_NS`=5 and grade 20, a read acknowledges after 5 edges and a write after 6 edges.
- R11: `ack` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, held by the host until `ack` |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| ack | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Access in progress |
| rd_data | output | 8 | Last byte read |
| mem_addr | output | 17 | Memory address pins |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 8 | Byte received from the data pins |

## Verification
The assertions assume that reset is applied before the first access. They also assume the host holds `req` until it sees `ack` and drops it no later than the following edge. The pulse-length checks count strobe cycles and compare them with the grade table, so they assume the parameters keep their elaborated values.

The directed stimulus changes `req` and the request fields only on falling clock edges, and only raises `req` from IDLE or from an acknowledge cycle. The memory model in the bench drives `mem_dq_in` only while the strobes select a read. It flags any cycle in which it and the controller drive the bus together.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOV
    } seq_state_t;

    // minimum times in ns per speed grade; unknown grades use the slowest row
    function automatic int grade_t_access(input int grade);
        case (grade)
            12:      return 12;
            15:      return 15;
            default: return 20;
        endcase
    endfunction

    function automatic int grade_t_pulse(input int grade);
        case (grade)
            12:      return 8;
            15:      return 12;
            default: return 15;
        endcase
    endfunction

    function automatic int grade_t_addr_end(input int grade);
        case (grade)
            12:      return 10;
            15:      return 12;
            default: return 15;
        endcase
    endfunction

    function automatic int grade_t_data_end(input int grade);
        case (grade)
            12:      return 7;
            15:      return 8;
            default: return 9;
        endcase
    endfunction

    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int rd_cycles(input int grade, input int period);
        return ns_to_cyc(grade_t_access(grade), period);
    endfunction

    function automatic int wp_cycles(input int grade, input int period);
        int c;
        c = ns_to_cyc(grade_t_pulse(grade), period);
        c = max_int(c, ns_to_cyc(grade_t_data_end(grade), period) + 1);
        c = max_int(c, ns_to_cyc(grade_t_addr_end(grade), period) - 1);
        return max_int(c, 1);
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_strobe_pkg::*;
#(
    parameter int RD_CYC  = 2,
    parameter int SU_CYC  = 1,
    parameter int WP_CYC  = 2,
    parameter int REC_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic req_wr,
    output logic accept,
    output logic rd_sample,
    output logic ack,
    output logic busy,
    output logic cs1_n,
    output logic cs2,
    output logic we_n,
    output logic oe_n,
    output logic dq_oe
);

    localparam int MAX_CYC = max_int(max_int(RD_CYC, SU_CYC), max_int(WP_CYC, REC_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    seq_state_t       state_q, state_nxt;
    logic             phase_done;
    logic             phase_load;
    logic [CNT_W-1:0] phase_len;
    logic             ack_set;

    sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase_load),
        .load_val (phase_len),
        .done     (phase_done)
    );

    // next-state and phase bookkeeping
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:      if (req && !ack) state_nxt = req_wr ? ST_WR_SETUP : ST_RD_ACCESS;
            ST_RD_ACCESS: if (phase_done)  state_nxt = ST_RD_TURN;
            ST_RD_TURN:                    state_nxt = ST_IDLE;
            ST_WR_SETUP:  if (phase_done)  state_nxt = ST_WR_PULSE;
            ST_WR_PULSE:  if (phase_done)  state_nxt = ST_WR_RECOV;
            ST_WR_RECOV:  if (phase_done)  state_nxt = ST_IDLE;
            default:                       state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_nxt)
            ST_RD_ACCESS: phase_len = CNT_W'(RD_CYC - 1);
            ST_WR_SETUP:  phase_len = CNT_W'(SU_CYC - 1);
            ST_WR_PULSE:  phase_len = CNT_W'(WP_CYC - 1);
            ST_WR_RECOV:  phase_len = CNT_W'(REC_CYC - 1);
            default:      phase_len = '0;
        endcase
    end

    assign phase_load = (state_nxt != state_q);
    assign accept     = (state_q == ST_IDLE) && (state_nxt != ST_IDLE);
    assign rd_sample  = (state_q == ST_RD_ACCESS) && phase_done;
    assign ack_set    = rd_sample || ((state_q == ST_WR_RECOV) && phase_done);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // registered strobes decoded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs1_n <= 1'b1;
            cs2   <= 1'b0;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
            ack   <= 1'b0;
            busy  <= 1'b0;
        end else begin
            ack <= ack_set;
            if (accept) begin
                busy <= 1'b1;
            end else if (ack_set) begin
                busy <= 1'b0;
            end
            unique case (state_nxt)
                ST_RD_ACCESS: begin
                    cs1_n <= 1'b0; cs2 <= 1'b1; we_n <= 1'b1; oe_n <= 1'b0; dq_oe <= 1'b0;
                end
                ST_WR_SETUP: begin
                    cs1_n <= 1'b0; cs2 <= 1'b1; we_n <= 1'b1; oe_n <= 1'b1; dq_oe <= 1'b0;
                end
                ST_WR_PULSE: begin
                    cs1_n <= 1'b0; cs2 <= 1'b1; we_n <= 1'b0; oe_n <= 1'b1;
                    dq_oe <= (state_q == ST_WR_PULSE);
                end
                ST_WR_RECOV: begin
                    cs1_n <= 1'b0; cs2 <= 1'b1; we_n <= 1'b1; oe_n <= 1'b1; dq_oe <= 1'b1;
                end
                default: begin
                    cs1_n <= 1'b1; cs2 <= 1'b0; we_n <= 1'b1; oe_n <= 1'b1; dq_oe <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              rd_sample,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] rd_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr <= '0;
            dq_out   <= '0;
        end else if (accept) begin
            mem_addr <= host_addr;
            dq_out   <= host_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_sample) begin
            rd_data <= dq_in;
        end
    end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_strobe_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int SPEED_GRADE   = 12,
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int RD_CYC  = rd_cycles(SPEED_GRADE, CLK_PERIOD_NS);
    localparam int WP_CYC  = wp_cycles(SPEED_GRADE, CLK_PERIOD_NS);
    localparam int SU_CYC  = ns_to_cyc(0, CLK_PERIOD_NS);
    localparam int REC_CYC = ns_to_cyc(0, CLK_PERIOD_NS);

    logic accept;
    logic rd_sample;

    sram_seq_fsm #(
        .RD_CYC  (RD_CYC),
        .SU_CYC  (SU_CYC),
        .WP_CYC  (WP_CYC),
        .REC_CYC (REC_CYC)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_wr    (req_wr),
        .accept    (accept),
        .rd_sample (rd_sample),
        .ack       (ack),
        .busy      (busy),
        .cs1_n     (mem_cs1_n),
        .cs2       (mem_cs2),
        .we_n      (mem_we_n),
        .oe_n      (mem_oe_n),
        .dq_oe     (mem_dq_oe)
    );

    sram_data_path #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) dp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .rd_sample  (rd_sample),
        .host_addr  (req_addr),
        .host_wdata (req_wdata),
        .dq_in      (mem_dq_in),
        .mem_addr   (mem_addr),
        .dq_out     (mem_dq_out),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk
    import sram_strobe_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int SPEED_GRADE   = 12
) (
    input logic clk,
    input logic rst_n,
    input logic ack,
    input logic busy,
    input logic mem_cs1_n,
    input logic mem_cs2,
    input logic mem_we_n,
    input logic mem_oe_n,
    input logic mem_dq_oe
);

    localparam int RD_CYC = rd_cycles(SPEED_GRADE, CLK_PERIOD_NS);
    localparam int WP_CYC = wp_cycles(SPEED_GRADE, CLK_PERIOD_NS);

    logic [15:0] we_low_cnt;
    logic [15:0] oe_low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
            oe_low_cnt <= '0;
        end else begin
            we_low_cnt <= mem_we_n ? 16'd0 : we_low_cnt + 16'd1;
            oe_low_cnt <= mem_oe_n ? 16'd0 : oe_low_cnt + 16'd1;
        end
    end

    a_r2_select_pair: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs1_n == !mem_cs2);

    a_r2_strobes_need_select: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || !mem_oe_n) |-> !mem_cs1_n);

    a_r3_no_drive_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    a_r3_read_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (oe_low_cnt >= 16'(RD_CYC)));

    a_r5_pulse_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt >= 16'(WP_CYC)));

    a_r6_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    a_r6_drive_after_we_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> ($past(!mem_we_n) && !mem_we_n));

    a_r6_drive_held_past_we: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe);

    a_r8_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |=> !mem_dq_oe);

    a_r9_busy_drops_at_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !busy);

    a_r11_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .SPEED_GRADE   (SPEED_GRADE)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .busy      (busy),
    .mem_cs1_n (mem_cs1_n),
    .mem_cs2   (mem_cs2),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_strobe_ctrl_tb_top.sv
module sram_model_tb (
    input  logic [16:0] addr,
    input  logic        cs1_n,
    input  logic        cs2,
    input  logic        we_n,
    input  logic        oe_n,
    input  logic [7:0]  dq_from_ctrl,
    input  logic        ctrl_drives,
    output logic [7:0]  dq_to_ctrl,
    output logic        clash
);
    logic [7:0] cells [256];
    logic       sel;
    logic       model_drives;

    initial begin
        for (int i = 0; i < 256; i++) cells[i] = 8'h00;
    end

    assign sel          = !cs1_n && cs2;
    assign model_drives = sel && we_n && !oe_n;
    assign dq_to_ctrl   = model_drives ? cells[addr[7:0]] : 8'hEE;
    assign clash        = model_drives && ctrl_drives;

    always @(posedge we_n) begin
        if (sel) cells[addr[7:0]] = ctrl_drives ? dq_from_ctrl : 8'hBD;
    end
endmodule

module sram_strobe_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // ---------- main instance: 10 ns clock, grade 12 ----------
    logic        req = 1'b0, req_wr = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ack, busy, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe, clash;
    logic [7:0]  rd_data, mem_dq_out, mem_dq_in;
    logic [16:0] mem_addr;

    sram_strobe_ctrl #(.CLK_PERIOD_NS(10), .SPEED_GRADE(12)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .ack(ack), .busy(busy), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

    sram_model_tb mem_i (
        .addr(mem_addr), .cs1_n(mem_cs1_n), .cs2(mem_cs2), .we_n(mem_we_n),
        .oe_n(mem_oe_n), .dq_from_ctrl(mem_dq_out), .ctrl_drives(mem_dq_oe),
        .dq_to_ctrl(mem_dq_in), .clash(clash));

    // ---------- second instance: 5 ns period parameter, grade 20 ----------
    logic        s_req = 1'b0, s_req_wr = 1'b0;
    logic [16:0] s_req_addr = '0;
    logic [7:0]  s_req_wdata = '0;
    logic        s_ack, s_busy, s_cs1_n, s_cs2, s_we_n, s_oe_n, s_dq_oe, s_clash;
    logic [7:0]  s_rd_data, s_dq_out, s_dq_in;
    logic [16:0] s_addr;

    sram_strobe_ctrl #(.CLK_PERIOD_NS(5), .SPEED_GRADE(20)) slow_i (
        .clk(clk), .rst_n(rst_n), .req(s_req), .req_wr(s_req_wr), .req_addr(s_req_addr),
        .req_wdata(s_req_wdata), .ack(s_ack), .busy(s_busy), .rd_data(s_rd_data),
        .mem_addr(s_addr), .mem_cs1_n(s_cs1_n), .mem_cs2(s_cs2),
        .mem_we_n(s_we_n), .mem_oe_n(s_oe_n), .mem_dq_out(s_dq_out),
        .mem_dq_oe(s_dq_oe), .mem_dq_in(s_dq_in));

    sram_model_tb s_mem_i (
        .addr(s_addr), .cs1_n(s_cs1_n), .cs2(s_cs2), .we_n(s_we_n),
        .oe_n(s_oe_n), .dq_from_ctrl(s_dq_out), .ctrl_drives(s_dq_oe),
        .dq_to_ctrl(s_dq_in), .clash(s_clash));

    // ---------- expected counts from the requirement tables ----------
    function automatic int cyc(input int ns, input int t);
        int c;
        c = (ns + t - 1) / t;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int exp_rd(input int g, input int t);
        return cyc((g == 12) ? 12 : (g == 15) ? 15 : 20, t);
    endfunction
    function automatic int exp_wp(input int g, input int t);
        int a, b, c, m;
        a = cyc((g == 12) ? 8 : (g == 15) ? 12 : 15, t);
        b = cyc((g == 12) ? 7 : (g == 15) ? 8 : 9, t) + 1;
        c = cyc((g == 12) ? 10 : (g == 15) ? 12 : 15, t) - 1;
        m = (a > b) ? a : b;
        m = (m > c) ? m : c;
        return (m < 1) ? 1 : m;
    endfunction

    localparam int RD = 2;  // exp_rd(12,10)
    localparam int WP = 2;  // exp_wp(12,10)

    task automatic check(input bit ok, input string req_tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
        end
    endtask

    // observations of the last transfer on dut_i
    int          o_lat, o_oe, o_we, o_drv, o_bad_addr, o_oe_in_wr, o_clash, o_busy_bad, o_desel_ack;
    logic [7:0]  o_rd;

    // call at a falling edge; leaves at the falling edge where ack is seen
    task automatic xfer(input logic wr, input logic [16:0] a, input logic [7:0] d, input bit scramble);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        o_lat = 0; o_oe = 0; o_we = 0; o_drv = 0; o_bad_addr = 0; o_oe_in_wr = 0;
        o_clash = 0; o_busy_bad = 0; o_desel_ack = 0;
        while (1) begin
            @(negedge clk);
            o_lat++;
            if (!mem_oe_n) o_oe++;
            if (!mem_we_n) o_we++;
            if (mem_dq_oe) o_drv++;
            if (wr && (!mem_cs1_n) && !mem_oe_n) o_oe_in_wr++;
            if (!mem_cs1_n && mem_addr != a) o_bad_addr++;
            if (clash) o_clash++;
            if (!ack && !busy && !(o_lat == 1 && mem_cs1_n)) o_busy_bad++;
            if (scramble) begin req_addr = ~a; req_wdata = ~d; req_wr = ~wr; end
            if (ack) begin
                o_desel_ack = (mem_cs1_n && !mem_cs2 && !mem_dq_oe) ? 1 : 0;
                break;
            end
            if (o_lat > 500) break;
        end
        o_rd = rd_data;
        req = 1'b0;
    endtask

    task automatic t_reset();
        check(mem_cs1_n == 1'b1 && mem_cs2 == 1'b0, "R1 select idle", {mem_cs1_n, mem_cs2}, 2);
        check(mem_we_n && mem_oe_n, "R1 we/oe idle", {mem_we_n, mem_oe_n}, 3);
        check(!mem_dq_oe && !ack && !busy, "R1 drive/ack/busy", {mem_dq_oe, ack, busy}, 0);
    endtask

    task automatic t_write_then_read(input logic [16:0] a, input logic [7:0] d);
        logic [7:0] prev;
        prev = rd_data;
        @(negedge clk);
        xfer(1'b1, a, d, 1'b0);
        check(o_lat == WP + 3, "R7 write latency", o_lat, WP + 3);
        check(o_we == WP, "R5 write pulse cycles", o_we, WP);
        check(o_drv == WP, "R6 drive cycles", o_drv, WP);
        check(o_oe_in_wr == 0, "R6 oe low during write", o_oe_in_wr, 0);
        check(o_bad_addr == 0, "R2 address during write", o_bad_addr, 0);
        check(o_rd == prev, "R4 rd_data held over write", o_rd, prev);
        @(negedge clk);
        xfer(1'b0, a, 8'h00, 1'b0);
        check(o_lat == RD + 1, "R4 read latency", o_lat, RD + 1);
        check(o_oe == RD, "R3 read strobe cycles", o_oe, RD);
        check(o_rd == d, "R4 read data", o_rd, d);
        check(o_clash == 0, "R3 no bus clash", o_clash, 0);
        check(o_desel_ack == 1, "R8 turnaround cycle", o_desel_ack, 1);
        check(o_busy_bad == 0, "R9 busy while active", o_busy_bad, 0);
    endtask

    task automatic t_scramble();
        @(negedge clk);
        xfer(1'b1, 17'h00034, 8'h96, 1'b1);
        check(o_bad_addr == 0, "R9 address ignored after accept", o_bad_addr, 0);
        @(negedge clk);
        xfer(1'b0, 17'h00034, 8'h00, 1'b0);
        check(o_rd == 8'h96, "R9 data ignored after accept", o_rd, 8'h96);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        xfer(1'b1, 17'h00051, 8'h3C, 1'b0);
        xfer(1'b0, 17'h00051, 8'h00, 1'b0);
        check(o_lat == RD + 2, "R9 read held across ack", o_lat, RD + 2);
        check(o_rd == 8'h3C, "R9 read after write data", o_rd, 8'h3C);
        xfer(1'b1, 17'h00052, 8'h7E, 1'b0);
        check(o_lat == WP + 4, "R8 write after read waits", o_lat, WP + 4);
        check(o_clash == 0, "R8 no clash after read", o_clash, 0);
        @(negedge clk);
        check(!ack, "R11 ack one cycle", ack, 0);
    endtask

    task automatic t_slow_grade();
        int lat;
        int exp_r, exp_w;
        exp_r = exp_rd(20, 5) + 1;
        exp_w = exp_wp(20, 5) + 3;
        @(negedge clk);
        s_req = 1'b1; s_req_wr = 1'b1; s_req_addr = 17'h00007; s_req_wdata = 8'hA5; lat = 0;
        while (1) begin @(negedge clk); lat++; if (s_ack || lat > 500) break; end
        s_req = 1'b0;
        check(lat == exp_w, "R10 write latency slow grade", lat, exp_w);
        @(negedge clk);
        s_req = 1'b1; s_req_wr = 1'b0; lat = 0;
        while (1) begin @(negedge clk); lat++; if (s_ack || lat > 500) break; end
        s_req = 1'b0;
        check(lat == exp_r, "R10 read latency slow grade", lat, exp_r);
        check(s_rd_data == 8'hA5, "R10 read data slow grade", s_rd_data, 8'hA5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_then_read(17'h00012, 8'h5A);
        t_write_then_read(17'h1FFFF, 8'hC3);
        t_write_then_read(17'h00000, 8'h00);
        t_scramble();
        t_back_to_back();
        t_slow_grade();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule